// File: doc/BRIEF.md
# Stair-Step Soft-Start Reference Sequencer

This block produces the digital code that sets the regulation reference of a power-factor controller after power-up. Once the supply monitor grants a run enable and AC input is present, the code climbs from a low starting value toward the final value one LSB at a time, with a fixed number of clocks spent on each step. With default parameters the final code stands for a 2.5 V reference. The product of step count and step length sets the ramp duration, which is nominally 5 ms.

When the final code is reached, a ramp-done flag rises. A second timer then measures a settling interval, nominally 30 ms, before a loop-select output moves regulation from the internal proportional loop to the external compensator. If the AC input is reported absent, or the run enable drops, the whole sequence collapses. The code returns to its starting value and the loop-select output goes back to the internal loop. The block then waits and ramps again from the beginning once conditions allow. The DAC that turns the code into a voltage is outside this block.

Top module: `ss_ref_sequencer`

## Requirements
- R1: In the first cycle after synchronous reset, ref_code equals START_CODE, ramp_done is 0 and ext_loop_sel is 0 (internal loop).
- R2: While run_en is 1 and ac_absent is 0, ref_code rises by exactly one after every STEP_CLKS such cycles, counted from the cycle the sequence last left its cleared state.
- R3: ref_code never exceeds FINAL_CODE and holds at FINAL_CODE once reached.
- R4: ramp_done becomes 1 in the same cycle in which ref_code first equals FINAL_CODE, and stays 1 while the sequence runs.
- R5: ext_loop_sel (1 = external compensator) becomes 1 exactly HOLD_CLKS running cycles after ramp_done rose, and stays 1 while the sequence runs.
- R6: A cycle with run_en 1 and ac_absent 1 returns ref_code to START_CODE and clears ramp_done and ext_loop_sel. A later ramp starts with a full first step.
- R7: A cycle with run_en 0 returns ref_code to START_CODE and clears ramp_done and ext_loop_sel.
- R8: ext_loop_sel is never 1 while ramp_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run grant from the under-voltage monitor |
| ac_absent | input | 1 | AC input reported missing |
| ref_code | output | CODE_W | Reference code for the DAC |
| ramp_done | output | 1 | Ramp has reached the final code |
| ext_loop_sel | output | 1 | 1 = external compensator, 0 = internal proportional loop |

## Verification
On every cycle, the assertions check the bounds of the code and its single-LSB increments. They also check that run_en low or ac_absent high clears the sequence on the next cycle, that loop selection depends on ramp_done, and that ramp_done matches the final code. A counter inside the checker confirms that the handover fires after exactly HOLD_CLKS cycles of completed ramp. The bench's scenarios show what a single cycle cannot: the exact step spacing, a restart that begins with a full first step after an AC dropout, saturation over a long run, and the precise cycles at which ramp_done and the handover appear.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic {
        LOOP_INTERNAL = 1'b0,
        LOOP_EXTERNAL = 1'b1
    } loop_sel_e;

    typedef enum logic [1:0] {
        SEQ_CLEARED,
        SEQ_RAMPING,
        SEQ_SETTLING,
        SEQ_HANDED_OVER
    } seq_phase_e;

    // Counter width able to hold values 0 .. n-1
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Phase implied by the ramp and loop-select state
    function automatic seq_phase_e phase_of(input logic done, input loop_sel_e sel);
        if (sel == LOOP_EXTERNAL) return SEQ_HANDED_OVER;
        if (done)                 return SEQ_SETTLING;
        return SEQ_RAMPING;
    endfunction

endpackage

// File: rtl/ss_step_tick.sv
module ss_step_tick #(
    parameter int STEP_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic tick
);
    localparam int CW = ss_pkg::cnt_width(STEP_CLKS);

    generate
        if (STEP_CLKS <= 1) begin : g_every_clock
            assign tick = advance;
        end else begin : g_prescale
            logic [CW-1:0] cnt;
            logic          last;

            assign last = (cnt == CW'(STEP_CLKS - 1));
            assign tick = advance && last;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    cnt <= '0;
                end else if (advance) begin
                    cnt <= last ? '0 : cnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ss_ref_ramp.sv
module ss_ref_ramp #(
    parameter int CODE_W     = 8,
    parameter int START_CODE = 40,
    parameter int FINAL_CODE = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              tick,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    localparam logic [CODE_W-1:0] CODE_LO = CODE_W'(START_CODE);
    localparam logic [CODE_W-1:0] CODE_HI = CODE_W'(FINAL_CODE);

    logic at_top;
    logic reach_top;

    assign at_top    = (code == CODE_HI);
    assign reach_top = tick && (code == CODE_HI - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            code <= CODE_LO;
            done <= 1'b0;
        end else begin
            if (tick && !at_top) begin
                code <= code + 1'b1;
            end
            if (reach_top) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ss_loop_handover.sv
module ss_loop_handover
    import ss_pkg::*;
#(
    parameter int HOLD_CLKS = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      ramp_done,
    output loop_sel_e sel
);
    localparam int HW = cnt_width(HOLD_CLKS);

    logic [HW-1:0] wait_cnt;
    logic          expire;

    assign expire = ramp_done && (sel == LOOP_INTERNAL) && (wait_cnt == HW'(HOLD_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wait_cnt <= '0;
            sel      <= LOOP_INTERNAL;
        end else if (ramp_done && sel == LOOP_INTERNAL) begin
            if (expire) begin
                sel <= LOOP_EXTERNAL;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ss_ref_sequencer.sv
module ss_ref_sequencer
    import ss_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int START_CODE = 40,
    parameter int FINAL_CODE = 50,
    parameter int STEP_CLKS  = 4,
    parameter int HOLD_CLKS  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              ac_absent,
    output logic [CODE_W-1:0] ref_code,
    output logic              ramp_done,
    output logic              ext_loop_sel
);
    logic       clear;
    logic       advance;
    logic       tick;
    loop_sel_e  sel;

    // Any missing run condition collapses the whole sequence
    assign clear   = !run_en || ac_absent;
    assign advance = !clear && !ramp_done;

    ss_step_tick #(
        .STEP_CLKS (STEP_CLKS)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .advance (advance),
        .tick    (tick)
    );

    ss_ref_ramp #(
        .CODE_W     (CODE_W),
        .START_CODE (START_CODE),
        .FINAL_CODE (FINAL_CODE)
    ) u_ramp (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .tick  (tick),
        .code  (ref_code),
        .done  (ramp_done)
    );

    ss_loop_handover #(
        .HOLD_CLKS (HOLD_CLKS)
    ) u_handover (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .ramp_done (ramp_done),
        .sel       (sel)
    );

    assign ext_loop_sel = (sel == LOOP_EXTERNAL);
endmodule

// File: rtl/ss_ref_sequencer_chk.sv
module ss_ref_sequencer_chk #(
    parameter int CODE_W     = 8,
    parameter int START_CODE = 40,
    parameter int FINAL_CODE = 50,
    parameter int HOLD_CLKS  = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic              ac_absent,
    input logic [CODE_W-1:0] ref_code,
    input logic              ramp_done,
    input logic              ext_loop_sel
);
    localparam logic [CODE_W-1:0] LO = CODE_W'(START_CODE);
    localparam logic [CODE_W-1:0] HI = CODE_W'(FINAL_CODE);

    // Age of the completed ramp, saturating just past the hold window
    int done_age;
    always_ff @(posedge clk) begin
        if (rst || !ramp_done) done_age <= 0;
        else if (done_age <= HOLD_CLKS) done_age <= done_age + 1;
    end

    assert_code_range_R3: assert property (@(posedge clk) disable iff (rst)
        (ref_code >= LO) && (ref_code <= HI));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run_en && !ac_absent) |=>
        (ref_code == $past(ref_code)) || (ref_code == $past(ref_code) + 1'b1));

    assert_absent_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (run_en && ac_absent) |=> (ref_code == LO) && !ramp_done && !ext_loop_sel);

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (ref_code == LO) && !ramp_done && !ext_loop_sel);

    assert_done_at_final_R4: assert property (@(posedge clk) disable iff (rst)
        ramp_done == (ref_code == HI));

    assert_ext_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
        ext_loop_sel |-> ramp_done);

    assert_handover_delay_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_loop_sel) |-> (done_age == HOLD_CLKS));
endmodule

bind ss_ref_sequencer ss_ref_sequencer_chk #(
    .CODE_W     (CODE_W),
    .START_CODE (START_CODE),
    .FINAL_CODE (FINAL_CODE),
    .HOLD_CLKS  (HOLD_CLKS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .run_en       (run_en),
    .ac_absent    (ac_absent),
    .ref_code     (ref_code),
    .ramp_done    (ramp_done),
    .ext_loop_sel (ext_loop_sel)
);

// File: tb/test_ss_ref_sequencer.sv
`timescale 1ns/1ps
module test_ss_ref_sequencer;
    localparam int CODE_W = 8;
    localparam int START  = 40;
    localparam int FINAL  = 50;
    localparam int STEP   = 4;
    localparam int HOLD   = 20;
    localparam int NRAMP  = (FINAL - START) * STEP;

    typedef struct packed {
        logic        run;
        logic        ac;
        logic [15:0] cycles;
        logic [7:0]  exp_ref;
        logic        exp_done;
        logic        exp_ext;
    } seg_t;

    localparam int NSEG = 10;
    localparam seg_t SEGS [NSEG] = '{
        '{1'b1, 1'b0, 16'd10, 8'd42, 1'b0, 1'b0},
        '{1'b1, 1'b1, 16'd3,  8'd40, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'd39, 8'd49, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'd1,  8'd50, 1'b1, 1'b0},
        '{1'b1, 1'b0, 16'd19, 8'd50, 1'b1, 1'b0},
        '{1'b1, 1'b0, 16'd1,  8'd50, 1'b1, 1'b1},
        '{1'b1, 1'b0, 16'd30, 8'd50, 1'b1, 1'b1},
        '{1'b0, 1'b0, 16'd2,  8'd40, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'd5,  8'd41, 1'b0, 1'b0},
        '{1'b1, 1'b1, 16'd1,  8'd40, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run_en = 1'b0;
    logic              ac_absent = 1'b0;
    logic [CODE_W-1:0] ref_code;
    logic              ramp_done;
    logic              ext_loop_sel;

    int n_checks = 0;
    int n_fails  = 0;
    int n_run    = 0;   // running cycles since the sequence was last cleared

    always #2.5 clk = ~clk;

    ss_ref_sequencer #(
        .CODE_W(CODE_W), .START_CODE(START), .FINAL_CODE(FINAL),
        .STEP_CLKS(STEP), .HOLD_CLKS(HOLD)
    ) i_ss_ref_sequencer (
        .clk(clk), .rst(rst), .run_en(run_en), .ac_absent(ac_absent),
        .ref_code(ref_code), .ramp_done(ramp_done), .ext_loop_sel(ext_loop_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_ref(input int n);
        int v = START + n / STEP;
        return (v > FINAL) ? FINAL : v;
    endfunction

    // One clock with the given inputs, then compare against the model
    task automatic cycle(input logic r, input logic a);
        string tr, td;
        run_en    = r;
        ac_absent = a;
        @(posedge clk);
        if (!r || a) n_run = 0; else n_run++;
        @(negedge clk);
        tr = !r ? "R7" : a ? "R6" : (n_run >= NRAMP) ? "R3" : "R2";
        td = !r ? "R7" : a ? "R6" : "R4";
        check(tr, int'(ref_code), model_ref(n_run));
        check(td, int'(ramp_done), int'(n_run >= NRAMP));
        check(!r ? "R7" : a ? "R6" : "R5", int'(ext_loop_sel), int'(n_run >= NRAMP + HOLD));
        if (ext_loop_sel && !ramp_done) check("R8", 1, 0);
    endtask

    initial begin : watchdog
        #200000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", int'(ref_code), START);
        check("R1", int'(ramp_done), 0);
        check("R1", int'(ext_loop_sel), 0);

        // Table-driven segments
        for (int s = 0; s < NSEG; s++) begin
            for (int c = 0; c < int'(SEGS[s].cycles); c++) begin
                cycle(SEGS[s].run, SEGS[s].ac);
            end
            check("R2", int'(ref_code), int'(SEGS[s].exp_ref));
            check("R4", int'(ramp_done), int'(SEGS[s].exp_done));
            check("R5", int'(ext_loop_sel), int'(SEGS[s].exp_ext));
        end

        // R6: dropout one clock before a step boundary restarts with a full step
        for (int c = 0; c < STEP - 1; c++) cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        for (int c = 0; c < STEP - 1; c++) cycle(1'b1, 1'b0);
        check("R6", int'(ref_code), START);
        cycle(1'b1, 1'b0);
        check("R6", int'(ref_code), START + 1);

        // R6: dropout after handover returns to the internal loop
        for (int c = 0; c < NRAMP + HOLD; c++) cycle(1'b1, 1'b0);
        check("R5", int'(ext_loop_sel), 1);
        cycle(1'b1, 1'b1);
        check("R6", int'(ext_loop_sel), 0);
        check("R6", int'(ref_code), START);

        // R1: reset in the middle of a ramp
        for (int c = 0; c < 2 * STEP + 1; c++) cycle(1'b1, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_run = 0;
        check("R1", int'(ref_code), START);
        check("R1", int'(ramp_done), 0);
        check("R1", int'(ext_loop_sel), 0);
        for (int c = 0; c < STEP; c++) cycle(1'b1, 1'b0);
        check("R2", int'(ref_code), START + 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule